// File: doc/BRIEF.md
# Divided Event Buffer Aggregation Manager

This block owns the acquisition memory of one channel pair. Software picks an organization value that cuts the memory into a power-of-two number of equal divisions, and a target event count per aggregate. Event words stream in on the write side, one word per cycle. Each accepted event is appended to the division currently being filled. When that division reaches the target count, it is closed and becomes readable, and filling moves on to the next division in ring order. A flush strobe can also close a division that holds only part of an aggregate.

The read side is started by a single request pulse. It answers with a four-word read header, then with as many aggregates as are ready, oldest first, up to a programmed limit. Each aggregate carries a two-word header followed by its event words. Reading the final word of an aggregate frees its division for reuse. Events are not accepted in two cases: the programmed aggregate cannot fit in one division, or no division is free. In both cases the block raises busy, and incoming events are dropped and counted.

Top module: `agg_event_buffer`

## Requirements
- R1: After reset, `readyAggs` and `lostCount` are 0 and `rdValid` and `rdLast` are low.
- R2: A division is closed and `readyAggs` rises by one on the final word of the event that brings the division to the `evPerAgg` count. A value of 0 in `evPerAgg` acts as 1.
- R3: Every event spans exactly 2 + `recSamples`/2 (rounded down) + `extraEn` words on the write side.
- R4: A flush pulse closes a division that holds at least one complete event. A flush has no effect in three cases: the division is empty, `wrValid` is high in that cycle, or an event is part-way through.
- R5: A read emits the following, with `rdLast` high only on the final word:
  - word 0 = {4'hA, 18'b0, aggregate count[9:0]}, followed by three zero words;
  - then, per aggregate, {4'h8, 12'b0, length[15:0]}, where length counts the two header words;
  - then {30'b0, `pairMask`};
  - then the event words in write order.
- R6: One request returns min(ready aggregates, `maxAggPerRead`) aggregates, oldest first, with 0 acting as 1. A request while nothing is ready produces no output. Each aggregate's division is released on its final word.
- R7: `orgSel` gives 2^orgSel divisions, with values above 10 treated as 10. Each division holds DEPTH >> orgSel words, and a setting beyond the memory gives zero capacity.
- R8: `busy` is high when `evPerAgg`·(event words) + 2 exceeds the division capacity, or when the division next in line is still unread. An event that starts while `busy` is high is dropped whole, and `lostCount` is incremented, saturating at its maximum.
- R9: When a division closes in the same cycle that a read releases another, `readyAggs` is left unchanged and both aggregates stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| orgSel | input | 4 | Division organization (2^orgSel divisions) |
| evPerAgg | input | 9 | Events per aggregate |
| recSamples | input | 8 | Samples per event record |
| extraEn | input | 1 | Adds one extra word per event |
| pairMask | input | 2 | Channel-pair enable mask reported in aggregate headers |
| maxAggPerRead | input | 10 | Aggregate limit per read request |
| wrValid | input | 1 | Event word valid |
| wrData | input | 32 | Event word |
| flushReq | input | 1 | Close the partly filled division |
| rdReq | input | 1 | Start a read |
| rdValid | output | 1 | Read word valid |
| rdData | output | 32 | Read word |
| rdLast | output | 1 | Final word of the read |
| busy | output | 1 | Overflow or no free division |
| readyAggs | output | 9 | Number of closed, unread divisions |
| lostCount | output | 16 | Dropped-event counter |

## Verification
The interaction that matters most is a division closing on the write side in the same cycle that the reader releases the previous one. In that cycle the ready count must take an increment and a decrement together. The bench provokes this by sweeping the start of a closing event across a range of delays while a one-aggregate read is in flight, so that one of the offsets lands on the release cycle. It then judges the outcome by the final ready count and by reading back the newly closed aggregate word for word.

// File: rtl/aggbuf_pkg.sv
package aggbuf_pkg;
  localparam int WORD_W = 32;
  localparam int LOST_W = 16;

  typedef enum logic [2:0] {
    RD_IDLE, RD_BHDR, RD_AHDR0, RD_AHDR1, RD_DATA
  } rdState_t;

  typedef enum logic [2:0] {
    SEL_BOARD, SEL_ZERO, SEL_AGGLEN, SEL_MASK, SEL_MEM
  } wordSel_t;

  typedef struct packed {
    logic     memWe;
    logic     outValid;
    logic     outLast;
    wordSel_t sel;
  } ctrlStrobe_t;
endpackage

// File: rtl/aggbuf_ctrl.sv
module aggbuf_ctrl
  import aggbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        orgSel,
  input  logic [8:0]        evPerAgg,
  input  logic [7:0]        recSamples,
  input  logic              extraEn,
  input  logic [9:0]        maxAggPerRead,
  input  logic              wrValid,
  input  logic              flushReq,
  input  logic              rdReq,
  output ctrlStrobe_t       strobe,
  output logic [AW-1:0]     memWaddr,
  output logic [AW-1:0]     memRaddr,
  output logic [9:0]        hdrCount,
  output logic [15:0]       hdrLen,
  output logic              busy,
  output logic [CW-1:0]     readyAggs,
  output logic [LOST_W-1:0] lostCount
);
  localparam int NDIV = DEPTH;

  // configuration decode
  logic [3:0]    orgClamp, orgIdx, shiftAmt;
  logic [CW-1:0] divCap, numDiv;
  logic [AW-1:0] divMask;
  logic [7:0]    evWords;
  logic [8:0]    evPerAggEff;
  logic [19:0]   aggNeed;
  logic          cfgOvf;

  always_comb begin
    orgClamp    = (orgSel > 4'd10) ? 4'd10 : orgSel;
    orgIdx      = (orgClamp > 4'(AW)) ? 4'(AW) : orgClamp;
    divCap      = (orgClamp > 4'(AW)) ? '0 : (CW'(DEPTH) >> orgClamp);
    numDiv      = CW'(1) << orgIdx;
    divMask     = AW'(numDiv - 1'b1);
    shiftAmt    = 4'(AW) - orgIdx;
    evWords     = 8'd2 + (recSamples >> 1) + {7'd0, extraEn};
    evPerAggEff = (evPerAgg == 9'd0) ? 9'd1 : evPerAgg;
    aggNeed     = 20'(evPerAggEff) * 20'(evWords) + 20'd2;
    cfgOvf      = aggNeed > 20'(divCap);
  end

  // division state
  logic          divReady [NDIV];
  logic [CW-1:0] divWords [NDIV];

  // write side
  logic [AW-1:0] wrDiv;
  logic [CW-1:0] wrOff;
  logic [8:0]    evCnt;
  logic [7:0]    wordIdx;
  logic          inEvent, dropping;
  logic          startWord, acceptStart, memWe, lastWord, evDone;
  logic          closeFull, doFlush, closeDiv;

  always_comb begin
    busy        = cfgOvf || divReady[wrDiv];
    startWord   = wrValid && !inEvent;
    acceptStart = startWord && !busy;
    memWe       = acceptStart || (wrValid && inEvent && !dropping);
    lastWord    = wrValid && inEvent && (wordIdx == evWords - 8'd1);
    evDone      = lastWord && !dropping;
    closeFull   = evDone && ((evCnt + 9'd1) == evPerAggEff);
    doFlush     = flushReq && !wrValid && !inEvent && (evCnt != 9'd0);
    closeDiv    = closeFull || doFlush;
    memWaddr    = AW'(CW'(wrDiv) << shiftAmt) + wrOff[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrDiv     <= '0;
      wrOff     <= '0;
      evCnt     <= '0;
      wordIdx   <= '0;
      inEvent   <= 1'b0;
      dropping  <= 1'b0;
      lostCount <= '0;
    end else begin
      if (startWord) begin
        inEvent  <= 1'b1;
        dropping <= !acceptStart;
        wordIdx  <= 8'd1;
        if (!acceptStart && !(&lostCount)) lostCount <= lostCount + 1'b1;
      end else if (wrValid && inEvent) begin
        if (lastWord) inEvent <= 1'b0;
        else          wordIdx <= wordIdx + 8'd1;
      end
      if (memWe)  wrOff <= wrOff + 1'b1;
      if (evDone) evCnt <= evCnt + 9'd1;
      if (closeDiv) begin
        wrDiv <= (wrDiv + 1'b1) & divMask;
        wrOff <= '0;
        evCnt <= '0;
      end
    end
  end

  // read side
  rdState_t      rdState;
  logic [1:0]    hdrIdx;
  logic [9:0]    aggLeft, maxEff, nTake, readyWide;
  logic [AW-1:0] rdDiv;
  logic [CW-1:0] rdOff, rdLen;
  logic          releaseDiv;

  always_comb begin
    maxEff     = (maxAggPerRead == 10'd0) ? 10'd1 : maxAggPerRead;
    readyWide  = 10'(readyAggs);
    nTake      = (readyWide < maxEff) ? readyWide : maxEff;
    rdLen      = divWords[rdDiv];
    hdrLen     = 16'(rdLen) + 16'd2;
    memRaddr   = AW'(CW'(rdDiv) << shiftAmt) + rdOff[AW-1:0];
    releaseDiv = (rdState == RD_DATA) && (rdOff == rdLen - 1'b1);

    strobe       = '0;
    strobe.memWe = memWe;
    strobe.sel   = SEL_ZERO;
    unique case (rdState)
      RD_BHDR: begin
        strobe.outValid = 1'b1;
        strobe.sel      = (hdrIdx == 2'd0) ? SEL_BOARD : SEL_ZERO;
      end
      RD_AHDR0: begin
        strobe.outValid = 1'b1;
        strobe.sel      = SEL_AGGLEN;
      end
      RD_AHDR1: begin
        strobe.outValid = 1'b1;
        strobe.sel      = SEL_MASK;
      end
      RD_DATA: begin
        strobe.outValid = 1'b1;
        strobe.sel      = SEL_MEM;
        strobe.outLast  = releaseDiv && (aggLeft == 10'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdState  <= RD_IDLE;
      hdrIdx   <= '0;
      aggLeft  <= '0;
      hdrCount <= '0;
      rdDiv    <= '0;
      rdOff    <= '0;
    end else begin
      unique case (rdState)
        RD_IDLE: if (rdReq && readyAggs != '0) begin
          rdState  <= RD_BHDR;
          hdrIdx   <= '0;
          aggLeft  <= nTake;
          hdrCount <= nTake;
        end
        RD_BHDR: begin
          hdrIdx <= hdrIdx + 2'd1;
          if (hdrIdx == 2'd3) rdState <= RD_AHDR0;
        end
        RD_AHDR0: rdState <= RD_AHDR1;
        RD_AHDR1: begin
          rdState <= RD_DATA;
          rdOff   <= '0;
        end
        RD_DATA: begin
          if (releaseDiv) begin
            rdOff <= '0;
            rdDiv <= (rdDiv + 1'b1) & divMask;
            if (aggLeft == 10'd1) rdState <= RD_IDLE;
            else begin
              aggLeft <= aggLeft - 10'd1;
              rdState <= RD_AHDR0;
            end
          end else begin
            rdOff <= rdOff + 1'b1;
          end
        end
        default: rdState <= RD_IDLE;
      endcase
    end
  end

  // shared division bookkeeping: a close and a release never hit the same division
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyAggs <= '0;
      for (int i = 0; i < NDIV; i++) begin
        divReady[i] <= 1'b0;
        divWords[i] <= '0;
      end
    end else begin
      if (releaseDiv) divReady[rdDiv] <= 1'b0;
      if (closeDiv) begin
        divReady[wrDiv] <= 1'b1;
        divWords[wrDiv] <= closeFull ? wrOff + 1'b1 : wrOff;
      end
      readyAggs <= readyAggs + CW'(closeDiv) - CW'(releaseDiv);
    end
  end
endmodule

// File: rtl/aggbuf_dpath.sv
module aggbuf_dpath
  import aggbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [AW-1:0]     memWaddr,
  input  logic [AW-1:0]     memRaddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [9:0]        hdrCount,
  input  logic [15:0]       hdrLen,
  input  logic [1:0]        pairMask,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              rdLast
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] outWord;

  always_ff @(posedge clk) begin
    if (strobe.memWe) mem[memWaddr] <= wrData;
  end

  always_comb begin
    unique case (strobe.sel)
      SEL_BOARD:  outWord = {4'hA, 18'd0, hdrCount};
      SEL_AGGLEN: outWord = {4'h8, 12'd0, hdrLen};
      SEL_MASK:   outWord = {30'd0, pairMask};
      SEL_MEM:    outWord = mem[memRaddr];
      default:    outWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdLast  <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.outValid;
      rdLast  <= strobe.outLast;
      if (strobe.outValid) rdData <= outWord;
    end
  end
endmodule

// File: rtl/agg_event_buffer.sv
module agg_event_buffer
  import aggbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        orgSel,
  input  logic [8:0]        evPerAgg,
  input  logic [7:0]        recSamples,
  input  logic              extraEn,
  input  logic [1:0]        pairMask,
  input  logic [9:0]        maxAggPerRead,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  input  logic              flushReq,
  input  logic              rdReq,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              rdLast,
  output logic              busy,
  output logic [CW-1:0]     readyAggs,
  output logic [LOST_W-1:0] lostCount
);
  ctrlStrobe_t   strobe;
  logic [AW-1:0] memWaddr, memRaddr;
  logic [9:0]    hdrCount;
  logic [15:0]   hdrLen;

  aggbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .orgSel(orgSel), .evPerAgg(evPerAgg),
    .recSamples(recSamples), .extraEn(extraEn), .maxAggPerRead(maxAggPerRead),
    .wrValid(wrValid), .flushReq(flushReq), .rdReq(rdReq), .strobe(strobe),
    .memWaddr(memWaddr), .memRaddr(memRaddr), .hdrCount(hdrCount), .hdrLen(hdrLen),
    .busy(busy), .readyAggs(readyAggs), .lostCount(lostCount)
  );

  aggbuf_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memWaddr(memWaddr),
    .memRaddr(memRaddr), .wrData(wrData), .hdrCount(hdrCount), .hdrLen(hdrLen),
    .pairMask(pairMask), .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast)
  );
endmodule

// File: rtl/aggbuf_checker.sv
module aggbuf_checker #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdValid,
  input logic          rdLast,
  input logic [31:0]   rdData,
  input logic [CW-1:0] readyAggs,
  input logic [15:0]   lostCount
);
  AST_READY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ({1'b0, readyAggs} <= {1'b0, $past(readyAggs)} + 1'b1)); // R2

  AST_LAST_IN_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid); // R5

  AST_BOARD_HDR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> (rdData[31:28] == 4'hA)); // R5

  AST_RELEASE_WITH_WORD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((readyAggs < $past(readyAggs)) -> rdValid)); // R6

  AST_LOST_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (lostCount >= $past(lostCount))); // R8
endmodule

bind agg_event_buffer aggbuf_checker #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdLast(rdLast),
  .rdData(rdData), .readyAggs(readyAggs), .lostCount(lostCount)
);

// File: tb/agg_event_buffer_bench.sv
module agg_event_buffer_bench;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  orgSel = 4'd2;
  logic [8:0]  evPerAgg = 9'd3;
  logic [7:0]  recSamples = 8'd8;
  logic        extraEn = 1'b0;
  logic [1:0]  pairMask = 2'b11;
  logic [9:0]  maxAggPerRead = 10'd2;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        flushReq = 1'b0;
  logic        rdReq = 1'b0;
  logic        rdValid, rdLast, busy;
  logic [31:0] rdData;
  logic [8:0]  readyAggs;
  logic [15:0] lostCount;

  agg_event_buffer #(.DEPTH(DEPTH)) u_agg_event_buffer (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  int unsigned dataQ[$];
  int          lenQ[$];
  int unsigned openQ[$];
  int          openEv = 0;
  int          lostExp = 0;

  function automatic int orgC();
    return (orgSel > 10) ? 10 : int'(orgSel);
  endfunction
  function automatic int evW();
    return 2 + int'(recSamples) / 2 + int'(extraEn);
  endfunction
  function automatic int perAgg();
    return (evPerAgg == 0) ? 1 : int'(evPerAgg);
  endfunction
  function automatic int numDiv();
    return 1 << ((orgC() > 8) ? 8 : orgC());
  endfunction
  function automatic int divCap();
    return (orgC() > 8) ? 0 : (DEPTH >> orgC());
  endfunction
  function automatic bit modelBusy();
    return (perAgg() * evW() + 2 > divCap()) || (lenQ.size() >= numDiv());
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic closeModel();
    lenQ.push_back(openQ.size());
    foreach (openQ[i]) dataQ.push_back(openQ[i]);
    openQ.delete();
    openEv = 0;
  endtask

  // R3: one event of evW() words; optional flush pulse on the second word
  task automatic writeEvent(bit flushMid = 0);
    bit keep = !modelBusy();
    int n = evW();
    int unsigned w;
    if (!keep) lostExp++;
    for (int i = 0; i < n; i++) begin
      w = $urandom;
      if (keep) openQ.push_back(w);
      @(negedge clk);
      wrValid = 1'b1;
      wrData = w;
      flushReq = flushMid && (i == 1);
    end
    @(negedge clk);
    wrValid = 1'b0;
    flushReq = 1'b0;
    if (keep) begin
      openEv++;
      if (openEv == perAgg()) closeModel();
    end
  endtask

  task automatic flushDiv();
    @(negedge clk);
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    if (openEv > 0) closeModel();
  endtask

  task automatic doRead(string req);
    int unsigned expQ[$];
    int unsigned gotQ[$];
    int maxE = (maxAggPerRead == 0) ? 1 : int'(maxAggPerRead);
    int n = (lenQ.size() < maxE) ? lenQ.size() : maxE;
    int mism = 0, firstAct = 0, firstExp = 0, len;
    bit seen = 0;
    if (n > 0) begin
      expQ.push_back({4'hA, 18'd0, 10'(n)});
      repeat (3) expQ.push_back(0);
      for (int a = 0; a < n; a++) begin
        len = lenQ.pop_front();
        expQ.push_back({4'h8, 12'd0, 16'(len + 2)});
        expQ.push_back({30'd0, pairMask});
        for (int k = 0; k < len; k++) expQ.push_back(dataQ.pop_front());
      end
    end
    @(negedge clk);
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
    if (n == 0) begin
      repeat (20) begin
        @(negedge clk);
        if (rdValid) seen = 1;
      end
      check(!seen, "R6", "empty read produced output", seen, 0);
    end else begin
      for (int t = 0; t < 3000; t++) begin
        @(negedge clk);
        if (rdValid) begin
          gotQ.push_back(rdData);
          if (rdLast) break;
        end
      end
      check(gotQ.size() == expQ.size(), req, "read stream length", gotQ.size(), expQ.size());
      foreach (expQ[i]) if (i < gotQ.size() && gotQ[i] != expQ[i]) begin
        if (mism == 0) begin
          firstAct = int'(gotQ[i]);
          firstExp = int'(expQ[i]);
        end
        mism++;
      end
      check(mism == 0, req, "read stream content first mismatch", firstAct, firstExp);
    end
  endtask

  task automatic checkState(string req);
    check(int'(readyAggs) == lenQ.size(), req, "readyAggs", readyAggs, lenQ.size());
    check(int'(lostCount) == lostExp, req, "lostCount", lostCount, lostExp);
  endtask

  task automatic drain();
    if (openEv > 0) flushDiv();
    while (lenQ.size() > 0) doRead("R6");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    // R1 reset state
    check(rdValid == 0 && rdLast == 0, "R1", "read outputs idle", rdValid, 0);
    check(readyAggs == 0, "R1", "readyAggs after reset", readyAggs, 0);
    check(lostCount == 0, "R1", "lostCount after reset", lostCount, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0, "R8", "busy with valid config", busy, 0);

    // R3 R4 R5: single event, flushed, read back
    writeEvent();
    checkState("R2");
    flushDiv();
    checkState("R4");
    doRead("R5");
    checkState("R5");

    // R4: flush on empty division has no effect
    flushDiv();
    check(readyAggs == 0, "R4", "flush on empty division", readyAggs, 0);

    // R2: close on the third event
    repeat (2) writeEvent();
    check(readyAggs == 0, "R2", "two of three events", readyAggs, 0);
    writeEvent();
    check(readyAggs == 1, "R2", "third event closes division", readyAggs, 1);

    // R4: flush during an event in progress ignored
    writeEvent(1'b1);
    checkState("R4");

    // R6: maxAggPerRead limit, oldest first
    repeat (2) writeEvent();
    repeat (3) writeEvent();
    checkState("R2");
    doRead("R6");
    checkState("R6");
    doRead("R6");
    doRead("R6");
    checkState("R6");

    // R7 R8: all four divisions held, further event dropped
    repeat (12) writeEvent();
    check(busy == 1, "R7", "busy with all divisions held", busy, 1);
    writeEvent();
    checkState("R8");
    maxAggPerRead = 10'd0;
    doRead("R6");
    check(busy == 0, "R8", "busy cleared after release", busy, 0);
    maxAggPerRead = 10'd4;
    drain();

    // R8: aggregate larger than a division
    evPerAgg = 9'd11;
    @(negedge clk);
    check(busy == 1, "R8", "oversized aggregate busy", busy, 1);
    writeEvent();
    checkState("R8");
    evPerAgg = 9'd10;
    @(negedge clk);
    check(busy == 0, "R8", "aggregate of 62 words fits 64", busy, 0);

    // R7: organization above memory gives zero capacity; org 0 is one division
    orgSel = 4'd12;
    @(negedge clk);
    check(busy == 1, "R7", "org beyond memory", busy, 1);
    orgSel = 4'd0;
    evPerAgg = 9'd0;
    extraEn = 1'b1;
    @(negedge clk);
    writeEvent();
    check(readyAggs == 1, "R2", "evPerAgg zero closes per event", readyAggs, 1);
    check(busy == 1, "R7", "single division held", busy, 1);
    writeEvent();
    checkState("R7");
    doRead("R3");

    // R9: close and release in the same cycle, offset sweep
    orgSel = 4'd2;
    evPerAgg = 9'd2;
    extraEn = 1'b0;
    maxAggPerRead = 10'd1;
    @(negedge clk);
    repeat (3) writeEvent();
    for (int d = 0; d < 24; d++) begin
      fork
        doRead("R9");
        begin
          repeat (d) @(negedge clk);
          writeEvent();
        end
      join
      check(readyAggs == 1, "R9", "ready count after overlap", readyAggs, 1);
      writeEvent();
    end
    drain();
    checkState("R9");

    // random mix
    orgSel = 4'd3;
    evPerAgg = 9'd3;
    maxAggPerRead = 10'd3;
    for (int i = 0; i < 150; i++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 6) writeEvent();
      else if (r < 7) flushDiv();
      else doRead("R5");
      checkState("R8");
    end
    drain();
    checkState("R6");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule